// File: doc/BRIEF.md
# SPI Master Shift Engine with DMA-Side Word Queue

This block is an SPI master that moves a burst of words between a DMA request/acknowledge handshake and the serial pins. A four-entry word queue sits between the DMA side and the shift engine. The block runs in one of two directions, which is chosen when the burst starts.

In transmit direction the block requests words from the DMA side while the queue has room and words remain to be fetched. It shifts each queued word out on MOSI, most significant bit first. In receive direction it shifts words in from MISO and places them in the queue for the DMA side to drain. While it receives, MOSI carries either zeros or the contents of a transmit data register.

Software starts a burst with a word count, a divider value and the mode bits. Chip select stays low from the start until a done pulse closes the burst. SPI mode 0 is fixed: SCK idles low, MISO is sampled on the rising SCK edge and MOSI changes after the falling edge.

Top module: `spi_dma_master`

## Requirements
- R1: After reset: cs_no=1, sck_o=0, dma_req_o=0, done_o=0, err_o=0, busy_o=0, txe_o=1 and rdr_o=0.
- R2: start_i is accepted while idle. It latches tx_mode_i (1 = transmit direction), overwrite_i, send_zero_i, word_cnt_i and clk_div_i, and empties the queue. In transmit direction dma_req_o is high while words remain to fetch and the 4-entry queue is not full. Each cycle with dma_req_o and dma_ack_i both high stores dma_wdata_i and uses up one word of the count. Exactly word_cnt_i words are accepted.
- R3: In transmit direction the accepted words appear on mosi_o in order of acceptance, MSB first. Each bit is stable at the rising edge of sck_o.
- R4: In transmit direction no word is started while the queue is empty. sck_o stays low, and txe_o is 1 exactly while the queue is empty.
- R5: Each high phase of sck_o lasts clk_div_i+1 clock cycles. cs_no is low from the cycle after start until the done pulse, and sck_o is never high while cs_no is high.
- R6: In receive direction the block shifts in word_cnt_i words from miso_i, MSB first, sampled on the rising SCK edge. A word that finds room goes into the queue and into rdr_o. dma_req_o is high while the queue holds data, and dma_rdata_o shows the oldest entry, which an acknowledge removes.
- R7: In receive direction, a word that finds the queue full while overwrite_i=1 replaces rdr_o. The queue contents stay unchanged and err_o pulses for one cycle.
- R8: In receive direction, a word that finds the queue full while overwrite_i=0 is dropped. rdr_o keeps its value and err_o pulses for one cycle.
- R9: In receive direction txe_o stays 1 and never causes err_o. MOSI sends all-zero words when send_zero_i=1 and the transmit data register (written by tdr_wr_i) when send_zero_i=0.
- R10: In transmit direction received data is ignored: rdr_o does not change and err_o stays low.
- R11: done_o is a one-cycle pulse. It comes once the count is used up, the queue is empty and the shifter is idle, and the block then returns to idle with cs_no=1. A zero word count gives the pulse without any SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a burst (ignored while busy) |
| tx_mode_i | input | 1 | 1 = transmit direction, 0 = receive direction |
| overwrite_i | input | 1 | Receive overflow policy: 1 overwrite rdr_o, 0 drop |
| send_zero_i | input | 1 | Receive direction MOSI source: 1 zeros, 0 transmit register |
| word_cnt_i | input | CNT_W | Words in the burst |
| clk_div_i | input | DIV_W | SCK half period minus one, in clock cycles |
| tdr_wr_i | input | 1 | Write strobe for the transmit data register |
| tdr_data_i | input | DATA_W | Transmit data register write value |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge |
| dma_wdata_i | input | DATA_W | Word from DMA (transmit direction) |
| dma_rdata_o | output | DATA_W | Oldest queued word for DMA (receive direction) |
| rdr_o | output | DATA_W | Receive data register |
| txe_o | output | 1 | Transmit side empty |
| err_o | output | 1 | Receive overflow error pulse |
| done_o | output | 1 | Burst complete pulse |
| busy_o | output | 1 | Burst in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
A corrupted queue pointer or fill count shows up within one word time. It appears as reordered, repeated or missing words on MOSI or dma_rdata_o, or as a wrong number of acknowledges before the request drops. A wrong word count or latched mode shows as an early or missing done pulse, or as rdr_o and err_o changing in the direction where they must hold. Divider or bit-counter faults are visible on the first SCK high phase, or in the width of the first serial word.

// File: rtl/spi_dma_pkg.sv
`timescale 1ns/1ps
package spi_dma_pkg;
  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } dma_mode_e;
endpackage

// File: rtl/spi_dma_fifo.sv
`timescale 1ns/1ps
module spi_dma_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_ok) rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_dma_clkdiv.sv
`timescale 1ns/1ps
module spi_dma_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_dma_shifter.sv
`timescale 1ns/1ps
module spi_dma_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] tx_word_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         sck_o,
  output logic         mosi_o,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_word_o
);
  localparam int unsigned BW = $clog2(W + 1);

  logic         busy_q, sck_q, vld_q;
  logic [W-1:0] tx_q, rx_q;
  logic [BW-1:0] bits_q;

  assign busy_o     = busy_q;
  assign sck_o      = sck_q;
  assign mosi_o     = tx_q[W-1];
  assign rx_valid_o = vld_q;
  assign rx_word_o  = rx_q;

  // mode 0: sample on rising SCK, advance on falling SCK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      vld_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bits_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          busy_q <= 1'b1;
          sck_q  <= 1'b0;
          tx_q   <= tx_word_i;
          bits_q <= BW'(W);
        end
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[W-2:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bits_q == BW'(1)) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
          end else begin
            bits_q <= bits_q - 1'b1;
            tx_q   <= {tx_q[W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_dma_master.sv
`timescale 1ns/1ps
module spi_dma_master
  import spi_dma_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DIV_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_mode_i,
  input  logic              overwrite_i,
  input  logic              send_zero_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              tdr_wr_i,
  input  logic [DATA_W-1:0] tdr_data_i,
  output logic              dma_req_o,
  input  logic              dma_ack_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic [DATA_W-1:0] dma_rdata_o,
  output logic [DATA_W-1:0] rdr_o,
  output logic              txe_o,
  output logic              err_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic              busy_q, ovw_q, szero_q, err_q, done_q;
  dma_mode_e         mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tdr_q, rdr_q;

  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_wdata, fifo_rdata;
  logic              sh_busy, sh_load, sh_rx_valid, tick;
  logic [DATA_W-1:0] sh_word, sh_rx_word;

  logic is_tx, is_rx, cnt_zero, start_ok, tx_push, rx_pop, rx_hit, rx_push, done_cond;

  always_comb begin
    is_tx      = busy_q && (mode_q == MODE_TX);
    is_rx      = busy_q && (mode_q == MODE_RX);
    cnt_zero   = (cnt_q == '0);
    start_ok   = start_i && !busy_q;
    dma_req_o  = is_tx ? (!cnt_zero && !fifo_full) : (is_rx && !fifo_empty);
    tx_push    = is_tx && dma_req_o && dma_ack_i;
    rx_pop     = is_rx && dma_req_o && dma_ack_i;
    rx_hit     = is_rx && sh_rx_valid;
    rx_push    = rx_hit && !fifo_full;
    fifo_push  = tx_push || rx_push;
    fifo_wdata = is_tx ? dma_wdata_i : sh_rx_word;
    // transmit waits for queued data; receive runs on the count alone
    sh_load    = !sh_busy && (is_tx ? !fifo_empty : (is_rx && !cnt_zero));
    fifo_pop   = rx_pop || (is_tx && sh_load);
    sh_word    = is_tx ? fifo_rdata : (szero_q ? '0 : tdr_q);
    done_cond  = busy_q && cnt_zero && fifo_empty && !sh_busy && !sh_rx_valid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_RX;
      ovw_q   <= 1'b0;
      szero_q <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
      tdr_q   <= '0;
      rdr_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start_ok) begin
        busy_q  <= 1'b1;
        mode_q  <= dma_mode_e'(tx_mode_i);
        ovw_q   <= overwrite_i;
        szero_q <= send_zero_i;
        div_q   <= clk_div_i;
        cnt_q   <= word_cnt_i;
      end else begin
        if (done_cond) busy_q <= 1'b0;
        if (tx_push || (is_rx && sh_load)) cnt_q <= cnt_q - 1'b1;
      end
      if (tdr_wr_i) tdr_q <= tdr_data_i;
      if (rx_hit && (!fifo_full || ovw_q)) rdr_q <= sh_rx_word;
      err_q  <= rx_hit && fifo_full;
      done_q <= done_cond;
    end
  end

  spi_dma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ok),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  spi_dma_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sh_busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_dma_shifter #(.W(DATA_W)) sh_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .tx_word_i  (sh_word),
    .tick_i     (tick),
    .miso_i     (miso_i),
    .busy_o     (sh_busy),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .rx_valid_o (sh_rx_valid),
    .rx_word_o  (sh_rx_word)
  );

  assign dma_rdata_o = is_rx ? fifo_rdata : '0;
  assign rdr_o       = rdr_q;
  assign txe_o       = is_tx ? fifo_empty : 1'b1;
  assign err_o       = err_q;
  assign done_o      = done_q;
  assign busy_o      = busy_q;
  assign cs_no       = !busy_q;
endmodule

// File: rtl/spi_dma_master_chk.sv
`timescale 1ns/1ps
module spi_dma_master_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              tx_i,
  input logic              ovw_i,
  input logic              req_i,
  input logic              full_i,
  input logic              sck_i,
  input logic              cs_ni,
  input logic              txe_i,
  input logic              err_i,
  input logic              done_i,
  input logic [DATA_W-1:0] rdr_i
);
  AST_REQ_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && tx_i && full_i |-> !req_i); // R2

  AST_SCK_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> !cs_ni); // R5

  AST_TXE_HELD_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !tx_i |-> txe_i); // R9

  AST_NO_ERR_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && tx_i |-> !err_i); // R10

  AST_RDR_KEPT_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !ovw_i |-> rdr_i == $past(rdr_i)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i && cs_ni); // R11

  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && ovw_i |=> !err_i || busy_i); // R7
endmodule

bind spi_dma_master spi_dma_master_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_o),
  .tx_i   (mode_q == spi_dma_pkg::MODE_TX),
  .ovw_i  (ovw_q),
  .req_i  (dma_req_o),
  .full_i (fifo_full),
  .sck_i  (sck_o),
  .cs_ni  (cs_no),
  .txe_i  (txe_o),
  .err_i  (err_o),
  .done_i (done_o),
  .rdr_i  (rdr_o)
);

// File: tb/spi_dma_master_tb_top.sv
`timescale 1ns/1ps
module spi_dma_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, tx_mode = 1'b0, ovw = 1'b0, sz = 1'b0;
  logic [15:0] wcnt = '0;
  logic [7:0]  div = '0;
  logic        tdr_wr = 1'b0;
  logic [7:0]  tdr_data = '0;
  logic        dma_req, dma_ack = 1'b0;
  logic [7:0]  dma_wdata = '0, dma_rdata, rdr;
  logic        txe, err, done, busy, sck, mosi, cs_n;
  logic        miso = 1'b0;

  int total = 0, bad = 0, cyc = 0, seed = 0;
  int n_ack, n_rd, err_cnt, done_cnt, txe_low, mo_n, mo_bits, si_bit, si_word;
  int sck_rises, rise_cyc, hp_bad;
  bit dma_en = 1'b1, drain_en = 1'b1;
  logic [7:0] mo_sh, tdr_val;
  logic [7:0] mo_w [64];
  logic [7:0] got [64];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_dma_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_mode_i(tx_mode),
    .overwrite_i(ovw), .send_zero_i(sz), .word_cnt_i(wcnt), .clk_div_i(div),
    .tdr_wr_i(tdr_wr), .tdr_data_i(tdr_data), .dma_req_o(dma_req),
    .dma_ack_i(dma_ack), .dma_wdata_i(dma_wdata), .dma_rdata_o(dma_rdata),
    .rdr_o(rdr), .txe_o(txe), .err_o(err), .done_o(done), .busy_o(busy),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  function automatic logic [7:0] txw(input int i);
    return 8'(i * 53 + seed * 7 + 17);
  endfunction
  function automatic logic [7:0] rxw(input int i);
    return 8'(i * 29 + seed * 11 + 165);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // DMA side model and event counters
  always @(negedge clk) begin
    if (err) err_cnt++;
    if (done) done_cnt++;
    if (busy && !tx_mode && !txe) txe_low++;
    if (tx_mode) begin
      if (dma_req && dma_en) begin
        dma_ack = 1'b1;
        dma_wdata = txw(n_ack);
        n_ack++;
      end else dma_ack = 1'b0;
    end else begin
      if (dma_req && drain_en) begin
        dma_ack = 1'b1;
        if (n_rd < 64) got[n_rd] = dma_rdata;
        n_rd++;
      end else dma_ack = 1'b0;
    end
  end

  // SPI slave model
  always @(posedge sck) begin
    mo_sh = {mo_sh[6:0], mosi};
    mo_bits++;
    if (mo_bits == 8) begin
      if (mo_n < 64) mo_w[mo_n] = mo_sh;
      mo_n++;
      mo_bits = 0;
    end
    rise_cyc = cyc;
    sck_rises++;
  end
  always @(negedge sck) begin
    logic [7:0] w;
    if (cyc - rise_cyc != int'(div) + 1) hp_bad++;
    si_bit++;
    if (si_bit == 8) begin
      si_bit = 0;
      si_word++;
    end
    w = rxw(si_word);
    miso = w[7 - si_bit];
  end

  task automatic run_burst(input bit m, input bit o, input bit z, input int n, input int d);
    logic [7:0] w;
    seed++;
    n_ack = 0; n_rd = 0; err_cnt = 0; done_cnt = 0; txe_low = 0;
    mo_n = 0; mo_bits = 0; si_bit = 0; si_word = 0; sck_rises = 0; hp_bad = 0;
    tx_mode = m; ovw = o; sz = z; wcnt = 16'(n); div = 8'(d);
    w = rxw(0);
    miso = w[7];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int k = 0;
    while (done_cnt == 0 && k < limit) begin
      @(negedge clk);
      k++;
    end
    if (done_cnt == 0) chk("R11 done timeout", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rdr_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_no", cs_n, 1);
    chk("R1 sck_o", sck, 0);
    chk("R1 dma_req_o", dma_req, 0);
    chk("R1 done_o", done, 0);
    chk("R1 err_o", err, 0);
    chk("R1 busy_o", busy, 0);
    chk("R1 txe_o", txe, 1);
    chk("R1 rdr_o", rdr, 0);

    // transmit sweep
    for (int d = 0; d < 3; d++) begin
      for (int n = 1; n <= 6; n++) begin
        rdr_before = rdr;
        run_burst(1'b1, 1'b0, 1'b0, n, d);
        wait_done(5000);
        chk("R2 words accepted", n_ack, n);
        chk("R3 words shifted", mo_n, n);
        for (int i = 0; i < n; i++) chk("R3 mosi word", mo_w[i], txw(i));
        chk("R5 sck high phase", hp_bad, 0);
        chk("R5 cs_no after burst", cs_n, 1);
        chk("R11 done pulses", done_cnt, 1);
        chk("R10 err_o in tx", err_cnt, 0);
        chk("R10 rdr_o held", rdr, rdr_before);
      end
    end

    // R4 and R2 fill limit: stall DMA, then slow shifting
    dma_en = 1'b0;
    run_burst(1'b1, 1'b0, 1'b0, 8, 50);
    repeat (100) @(negedge clk);
    chk("R4 no sck without data", sck_rises, 0);
    chk("R4 txe_o while empty", txe, 1);
    chk("R2 req while room", dma_req, 1);
    chk("R5 cs_no low in burst", cs_n, 0);
    dma_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2 acks until full", n_ack, 5);
    chk("R2 req drops when full", dma_req, 0);
    chk("R4 txe_o with data", txe, 0);
    wait_done(20000);
    chk("R2 total accepted", n_ack, 8);
    for (int i = 0; i < 8; i++) chk("R3 mosi word slow", mo_w[i], txw(i));
    chk("R5 sck high phase slow", hp_bad, 0);

    // transmit data register for receive tests
    tdr_val = 8'h3C;
    @(negedge clk) begin tdr_wr = 1'b1; tdr_data = tdr_val; end
    @(negedge clk) tdr_wr = 1'b0;

    // receive sweep
    for (int d = 0; d < 3; d++) begin
      for (int n = 1; n <= 6; n++) begin
        bit z;
        z = 1'((n + d) % 2);
        run_burst(1'b0, 1'b0, z, n, d);
        wait_done(5000);
        chk("R6 words drained", n_rd, n);
        for (int i = 0; i < n; i++) chk("R6 dma_rdata word", got[i], rxw(i));
        chk("R6 rdr_o last word", rdr, rxw(n - 1));
        for (int i = 0; i < n; i++) chk("R9 mosi in rx", mo_w[i], z ? 0 : tdr_val);
        chk("R9 txe_o held", txe_low, 0);
        chk("R9 no err", err_cnt, 0);
        chk("R5 sck high phase rx", hp_bad, 0);
        chk("R11 done pulses rx", done_cnt, 1);
      end
    end

    // R7 / R8 overflow with DMA stalled
    for (int o = 0; o < 2; o++) begin
      int k = 0;
      drain_en = 1'b0;
      run_burst(1'b0, 1'(o), 1'b1, 6, 1);
      while (mo_n < 6 && k < 5000) begin
        @(negedge clk);
        k++;
      end
      repeat (10) @(negedge clk);
      if (o == 1) begin
        chk("R7 err pulses", err_cnt, 2);
        chk("R7 rdr_o overwritten", rdr, rxw(5));
      end else begin
        chk("R8 err pulses", err_cnt, 2);
        chk("R8 rdr_o kept", rdr, rxw(3));
      end
      chk("R11 no done before drain", done_cnt, 0);
      drain_en = 1'b1;
      wait_done(2000);
      chk(o ? "R7 queue drained" : "R8 queue drained", n_rd, 4);
      for (int i = 0; i < 4; i++) chk(o ? "R7 queue word" : "R8 queue word", got[i], rxw(i));
    end

    // R11 zero count
    run_burst(1'b1, 1'b0, 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11 zero count done", done_cnt, 1);
    chk("R11 zero count no sck", sck_rises, 0);
    chk("R11 idle cs_no", cs_n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule